// File: doc/BRIEF.md
# Compare Match Timer Channel

This block is one channel of a periodic timer. A 16-bit up-counter advances on a prescaled tick taken from the peripheral clock. A 2-bit clock select in the control/status register picks one of four division ratios. Counting happens only while the external start input is high. When the counter holds the compare value at a counting tick, it returns to zero and a match flag is set. The counter therefore repeats every compare value plus one ticks. The flag drives an interrupt request when the interrupt enable is set.

Software clears the flag with a guarded handshake: it reads the flag as 1, then writes 0 to it. If a new match lands between that read and the write, the write leaves the flag set, so no event is lost. A transfer controller that services the interrupt can also clear the flag through a one-cycle sideband strobe.

All three registers sit on a simple synchronous bus. Writes take effect at the clock edge. Read data is combinational from the selected register.

Top module: `mt_channel`

## Requirements
- R1: After reset the control/status register reads 0x0000, the counter reads 0x0000, the compare register reads 0xFFFF and irq_o is 0.
- R2: The control/status register (address 0) holds the match flag in bit 7, the interrupt enable in bit 6 and the clock select in bits 1:0. Bits 15:8 and 5:2 always read 0.
- R3: Clock select 0 advances the counter once every 8 clocks, 1 every 32 clocks, 2 every 128 clocks and 3 every 512 clocks. The prescaler runs freely from reset, so any window of N·div consecutive clocks holds exactly N ticks.
- R4: While run_en is 0 the counter holds its value.
- R5: At a counting tick where the counter (address 1) equals the compare register (address 2), the counter returns to 0 and the match flag is set. Matches therefore recur every compare value plus 1 ticks.
- R6: A bus write to the counter in a cycle that is also a counting tick loads the written value, and the tick is lost.
- R7: A write of 0 to bit 7 clears the flag only if the flag was read as 1 beforehand. A write of 0 with no such read leaves the flag set. Writing 1 to bit 7 never changes the flag.
- R8: If a match occurs after the qualifying read and before the write of 0, that write leaves the flag set. A fresh read of 1 then re-enables the clear.
- R9: irq_o is 1 exactly when both the match flag and the interrupt enable are 1.
- R10: A one-cycle pulse on xfer_clr clears the match flag without any prior read.
- R11: The counter and compare registers read back the last value written to them while no count occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | 0 control/status, 1 counter, 2 compare |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed register, 0 for address 3 |
| run_en | input | 1 | Start control; the counter advances only while it is 1 |
| xfer_clr | input | 1 | Flag clear strobe from the transfer controller |
| irq_o | output | 1 | Compare match interrupt request |

## Verification
The hardest situation to reach from the ports is a match that falls between the qualifying read and the clearing write. The bench creates it by stopping the counter right after a first match and reading the flag, which arms the clear. It then runs exactly one further match period before it writes 0. Counts are made exact without any view of the prescaler phase: the start input is held high for a whole multiple of the division ratio. The bench also catches a counter write landing on a hidden tick edge. It repeats single-edge writes at a spacing of three cycles, which is coprime to the divisor, so one of the eight trials is certain to hit a tick.

// File: rtl/mt_pkg.sv
package mt_pkg;
  localparam int unsigned DW = 16;
  localparam int unsigned FLAG_BIT = 7;
  localparam int unsigned IE_BIT = 6;
  localparam int unsigned SEL_W = 2;

  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_COUNT = 2'd1,
    REG_MATCH = 2'd2,
    REG_NONE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/mt_prescaler.sv
module mt_prescaler #(
  parameter int unsigned SEL_W    = 2,
  parameter int unsigned BASE_LOG = 3,
  parameter int unsigned STEP_LOG = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int unsigned NTAP  = 1 << SEL_W;
  localparam int unsigned PRE_W = BASE_LOG + STEP_LOG * (NTAP - 1);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [NTAP-1:0]  tap;

  always_comb pre_d = pre_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  // each tap fires when its low-order prescaler bits are all ones
  for (genvar i = 0; i < NTAP; i++) begin : g_tap
    localparam logic [PRE_W-1:0] MASK = PRE_W'((1 << (BASE_LOG + STEP_LOG * i)) - 1);
    assign tap[i] = ((pre_q & MASK) == MASK);
  end

  assign tick = tap[sel];
endmodule

// File: rtl/mt_count_cmp.sv
module mt_count_cmp #(
  parameter int unsigned DW = 16,
  parameter logic [DW-1:0] CMP_RST = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          wr_cnt,
  input  logic          wr_cmp,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] cnt_q,
  output logic [DW-1:0] cmp_q,
  output logic          match
);
  logic [DW-1:0] cnt_d, cmp_d;
  logic          equal;

  assign equal = (cnt_q == cmp_q);
  // a bus write to the counter suppresses the tick and its match
  assign match = tick_en && equal && !wr_cnt;

  always_comb begin
    cnt_d = cnt_q;
    if (wr_cnt)       cnt_d = wdata;
    else if (tick_en) cnt_d = equal ? '0 : cnt_q + 1'b1;
  end

  always_comb begin
    cmp_d = cmp_q;
    if (wr_cmp) cmp_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cmp_q <= CMP_RST;
    end else begin
      cnt_q <= cnt_d;
      cmp_q <= cmp_d;
    end
  end
endmodule

// File: rtl/mt_match_flag.sv
module mt_match_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic match,
  input  logic rd_ctrl,
  input  logic wr_ctrl,
  input  logic wr_flag_bit,
  input  logic xfer_clr,
  input  logic ie,
  output logic flag_q,
  output logic armed_q,
  output logic irq
);
  logic flag_d, armed_d, clr_req;

  assign clr_req = (wr_ctrl && !wr_flag_bit && armed_q) || xfer_clr;

  always_comb begin
    flag_d  = flag_q;
    armed_d = armed_q;
    if (rd_ctrl && flag_q) armed_d = 1'b1;
    if (clr_req) begin
      flag_d  = 1'b0;
      armed_d = 1'b0;
    end
    // a new match wins over any clear and voids a pending read
    if (match) begin
      flag_d  = 1'b1;
      armed_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      flag_q  <= flag_d;
      armed_q <= armed_d;
    end
  end

  assign irq = flag_q & ie;
endmodule

// File: rtl/mt_channel.sv
module mt_channel
  import mt_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          run_en,
  input  logic          xfer_clr,
  output logic          irq_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_q_n;
  reg_sel_e         rsel;
  logic             wr_ctrl, rd_ctrl, wr_cnt, wr_cmp;
  logic             ie_q, ie_d;
  logic [SEL_W-1:0] cks_q, cks_d;
  logic             tick, tick_en, match;
  logic [DW-1:0]    cnt_q, cmp_q;
  logic             flag_q, armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  assign rsel    = reg_sel_e'(bus_addr);
  assign wr_ctrl = bus_sel &&  bus_wr && (rsel == REG_CTRL);
  assign rd_ctrl = bus_sel && !bus_wr && (rsel == REG_CTRL);
  assign wr_cnt  = bus_sel &&  bus_wr && (rsel == REG_COUNT);
  assign wr_cmp  = bus_sel &&  bus_wr && (rsel == REG_MATCH);

  always_comb begin
    ie_d  = ie_q;
    cks_d = cks_q;
    if (wr_ctrl) begin
      ie_d  = bus_wdata[IE_BIT];
      cks_d = bus_wdata[SEL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      ie_q  <= 1'b0;
      cks_q <= '0;
    end else begin
      ie_q  <= ie_d;
      cks_q <= cks_d;
    end
  end

  mt_prescaler #(.SEL_W(SEL_W), .BASE_LOG(3), .STEP_LOG(2)) u_pre (
    .clk  (clk),
    .rst_n(rst_q_n),
    .sel  (cks_q),
    .tick (tick)
  );

  assign tick_en = tick && run_en;

  mt_count_cmp #(.DW(DW), .CMP_RST('1)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .tick_en(tick_en),
    .wr_cnt (wr_cnt),
    .wr_cmp (wr_cmp),
    .wdata  (bus_wdata),
    .cnt_q  (cnt_q),
    .cmp_q  (cmp_q),
    .match  (match)
  );

  mt_match_flag u_flag (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .match      (match),
    .rd_ctrl    (rd_ctrl),
    .wr_ctrl    (wr_ctrl),
    .wr_flag_bit(bus_wdata[FLAG_BIT]),
    .xfer_clr   (xfer_clr),
    .ie         (ie_q),
    .flag_q     (flag_q),
    .armed_q    (armed_q),
    .irq        (irq_o)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (rsel)
      REG_CTRL: begin
        bus_rdata[FLAG_BIT]  = flag_q;
        bus_rdata[IE_BIT]    = ie_q;
        bus_rdata[SEL_W-1:0] = cks_q;
      end
      REG_COUNT: bus_rdata = cnt_q;
      REG_MATCH: bus_rdata = cmp_q;
      REG_NONE:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/mt_channel_chk.sv
module mt_channel_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        run_en,
  input logic        tick,
  input logic        wr_cnt,
  input logic        match,
  input logic [15:0] cnt_q,
  input logic        flag_q,
  input logic        armed_q,
  input logic        ie_q,
  input logic        xfer_clr,
  input logic        irq_o,
  input logic [1:0]  bus_addr,
  input logic [15:0] bus_rdata
);
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd0) |-> (bus_rdata[15:8] == 8'h00 && bus_rdata[5:2] == 4'h0));

  a_r3_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  a_r4_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !wr_cnt) |=> $stable(cnt_q));

  a_r5_wrap_and_flag: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> (cnt_q == 16'h0000 && flag_q));

  a_r7_no_blind_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !armed_q && !xfer_clr) |=> flag_q);

  a_r8_match_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> !armed_q);

  a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !ie_q |-> !irq_o);

  a_r10_xfer_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_clr && !match) |=> !flag_q);
endmodule

bind mt_channel mt_channel_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_q_n),
  .run_en   (run_en),
  .tick     (tick),
  .wr_cnt   (wr_cnt),
  .match    (match),
  .cnt_q    (cnt_q),
  .flag_q   (flag_q),
  .armed_q  (armed_q),
  .ie_q     (ie_q),
  .xfer_clr (xfer_clr),
  .irq_o    (irq_o),
  .bus_addr (bus_addr),
  .bus_rdata(bus_rdata)
);

// File: tb/mt_channel_tb_top.sv
module mt_channel_tb_top;
  logic        clk;
  logic        rst_n;
  logic        bus_sel;
  logic        bus_wr;
  logic [1:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        run_en;
  logic        xfer_clr;
  logic        irq_o;

  int n_tests = 0;
  int n_fail  = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  mt_channel dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .run_en(run_en), .xfer_clr(xfer_clr), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // monitor: a read is active between drive (edge+1) and the next edge
  always @(negedge clk) begin
    if (rst_n && bus_sel && !bus_wr) begin
      logic [15:0] e;
      string t;
      n_tests++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL scoreboard: read with no expected item, got %h", bus_rdata);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          n_fail++;
          $display("FAIL %s: read %h expected %h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic read_expect(input logic [1:0] a, input logic [15:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(posedge clk); #1;
    bus_sel = 1'b0;
  endtask

  task automatic run_for(input int m);
    run_en = 1'b1;
    repeat (m) @(posedge clk);
    #1;
    run_en = 1'b0;
  endtask

  task automatic check_irq(input logic e, input string t);
    n_tests++;
    if (irq_o !== e) begin
      n_fail++;
      $display("FAIL %s: irq_o %b expected %b", t, irq_o, e);
    end
  endtask

  task automatic rate_case(input logic [1:0] sel, input int div, input int n);
    bus_write(2'd0, 16'h0080 | {14'd0, sel});
    bus_write(2'd1, 16'h0000);
    run_for(n * div);
    read_expect(2'd1, 16'(n), "R3");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 2'd0;
    bus_wdata = 16'h0000; run_en = 1'b0; xfer_clr = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;

    // R1 reset state
    check_irq(1'b0, "R1");
    read_expect(2'd0, 16'h0000, "R1");
    read_expect(2'd1, 16'h0000, "R1");
    read_expect(2'd2, 16'hFFFF, "R1");
    read_expect(2'd3, 16'h0000, "R2");

    // R11 readback
    bus_write(2'd2, 16'h1234);
    read_expect(2'd2, 16'h1234, "R11");
    bus_write(2'd1, 16'h00AB);
    read_expect(2'd1, 16'h00AB, "R11");

    // R2 layout: reserved bits read 0, bit7=1 write has no effect (R7)
    bus_write(2'd0, 16'hFFFF);
    read_expect(2'd0, 16'h0043, "R2");
    bus_write(2'd0, 16'h0080);
    read_expect(2'd0, 16'h0000, "R7");

    // R3 prescaler ratios, R4 hold
    bus_write(2'd2, 16'hFFFF);
    rate_case(2'd0, 8, 10);
    rate_case(2'd1, 32, 5);
    rate_case(2'd2, 128, 2);
    rate_case(2'd3, 512, 3);
    repeat (600) @(posedge clk);
    #1;
    read_expect(2'd1, 16'h0003, "R4");

    // R6 counter write vs tick: spacing 3 covers all 8 phases
    bus_write(2'd0, 16'h0080);
    for (int i = 0; i < 8; i++) begin
      run_en = 1'b1;
      bus_write(2'd1, 16'h0100 + 16'(i));
      run_en = 1'b0;
      read_expect(2'd1, 16'h0100 + 16'(i), "R6");
      @(posedge clk); #1;
    end

    // R5 match wraps counter and sets flag
    bus_write(2'd2, 16'h0003);
    bus_write(2'd1, 16'h0000);
    run_for(32);
    read_expect(2'd1, 16'h0000, "R5");
    // R7 blind write of 0 keeps flag
    bus_write(2'd0, 16'h0000);
    read_expect(2'd0, 16'h0080, "R7");
    bus_write(2'd0, 16'h0080);
    read_expect(2'd0, 16'h0080, "R7");
    bus_write(2'd0, 16'h0000);
    read_expect(2'd0, 16'h0000, "R7");

    // R8 match between read and write
    run_for(32);
    read_expect(2'd0, 16'h0080, "R5");
    run_for(32);
    bus_write(2'd0, 16'h0000);
    read_expect(2'd0, 16'h0080, "R8");
    bus_write(2'd0, 16'h0000);
    read_expect(2'd0, 16'h0000, "R8");

    // R9 interrupt gating, R10 sideband clear
    run_for(32);
    check_irq(1'b0, "R9");
    bus_write(2'd0, 16'h00C0);
    check_irq(1'b1, "R9");
    bus_write(2'd0, 16'h0080);
    check_irq(1'b0, "R9");
    bus_write(2'd0, 16'h00C0);
    check_irq(1'b1, "R9");
    xfer_clr = 1'b1;
    @(posedge clk); #1;
    xfer_clr = 1'b0;
    check_irq(1'b0, "R10");
    read_expect(2'd0, 16'h0040, "R10");

    repeat (3) @(posedge clk);
    #1;
    n_tests++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard: %0d reads outstanding expected 0", exp_q.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule